// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

This block is a synthesizable cycle model of a burst-capable synchronous static RAM with a 32-bit word in four 8-bit byte lanes. A bus master begins an access with one of two address strobes: a processor-side strobe, which only ever reads, or a controller-side strobe, which reads or writes depending on the write inputs sampled with it. After the first access, a burst-advance input steps a 2-bit counter through up to four words. The counter's order is either interleaved (XOR of the start offset) or linear (modulo-4 addition).

Three chip enables qualify every new access. The master enable gates the processor strobe only. Read data comes back either through a second output register (pipelined) or straight from the address register (flow-through). An asynchronous output enable and any sampled byte write control whether the data bus is driven. The bidirectional bus is split into separate input, output and drive-enable ports.

Top module: `bsram_core`

## Requirements
- R1: With all three enables active (master low, high-enable high, low-enable low), a low processor strobe starts a read at `addr`. The write inputs and the controller strobe have no effect on that edge.
- R2: While the master enable is high, a low processor strobe is ignored: with the controller strobe high, the current burst goes on without stepping. A low controller strobe with the master enable high deselects.
- R3: A low controller strobe with the processor strobe high and all enables active starts an access at `addr`. The write inputs sampled on that same edge decide read or write, and write data on `din` is captured on that edge.
- R4: On an edge where the processor strobe starts a cycle, `adv_n` and the lane strobes are ignored: the access uses offset 0 and writes nothing.
- R5: During a burst, the counter steps by one only when `adv_n` is low and both strobes are high. With `adv_n` high, the same word is accessed again.
- R6: With `burst_ilv`=1, the word offsets of a burst are start XOR 0, 1, 2, 3.
- R7: With `burst_ilv`=0, the word offsets of a burst are start plus 0, 1, 2, 3, modulo 4.
- R8: `gw_n` low writes all four lanes. With `gw_n` high and `bw_n` low, lane i (bits 8i+7..8i) is written when `lane_we_n[i]` is low. If no lane is selected, or `bw_n` is high, the cycle is a read.
- R9: With `pipe_en`=1, data for a read registered on edge k is valid after edge k+1. With `pipe_en`=0, it is valid after edge k.
- R10: `dout_en` is high only when `oe_n` is low and a read result is present. A byte write sampled on the last edge holds `dout_en` low whatever `oe_n` is. `oe_n` acts without a clock.
- R11: A deselect ends the burst. In pipelined mode, the read issued just before the deselect is still driven for one cycle, and after that the bus is undriven.
- R12: A synchronous high `rst` clears the burst state and both output stages, so `dout_en` is low after the reset edge and no burst continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_hi | input | 1 | Chip enable, active high |
| ce_lo_n | input | 1 | Chip enable, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | 4 | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | 1 = interleaved order, 0 = linear |
| pipe_en | input | 1 | 1 = pipelined, 0 = flow-through |
| addr | input | 8 | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Read data (zero when not driven) |
| dout_en | output | 1 | Bus drive enable |

## Verification
A wrong burst counter or a mis-latched start offset appears at the very next data beat as the wrong word on `dout`. The bench therefore fills the words of a four-word group with distinct values and reads them back in both orders and both latencies. A write decoded wrongly shows up as a corrupted word, or an untouched one, on the next read of that address, usually within three cycles. A stale valid or write flag in the output stages shows up as `dout_en` being wrong one or two cycles after a deselect, a write or a reset.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_START = 2'd1,
      CYC_CONT  = 2'd2,
      CYC_DESEL = 2'd3
   } cyc_kind_e;

   // word offset within a 4-word group for burst step 'step'
   function automatic logic [1:0] burst_ofs(input logic [1:0] seed,
                                            input logic [1:0] step,
                                            input logic       ilv);
      return ilv ? (seed ^ step) : (seed + step);
   endfunction

endpackage

// File: rtl/bsram_ctl.sv
module bsram_ctl
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_main_n,
   input  logic              ce_hi,
   input  logic              ce_lo_n,
   input  logic              pstrb_n,
   input  logic              cstrb_n,
   input  logic              adv_n,
   input  logic              gw_n,
   input  logic              bw_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              burst_ilv,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [LANES-1:0]  wr_mask,
   output logic              rd_go
);
   localparam int GRP_W = ADDR_W - 2;

   logic              active_q;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   logic [1:0]        cnt_nx;
   logic              ens_ok, p_eff, step_go;
   logic [LANES-1:0]  wmask_raw;
   cyc_kind_e         kind;

   always_comb begin
      ens_ok = !ce_main_n && ce_hi && !ce_lo_n;
      p_eff  = !pstrb_n && !ce_main_n;
      if (p_eff)
         kind = ens_ok ? CYC_START : CYC_DESEL;
      else if (!cstrb_n)
         kind = (pstrb_n && ens_ok) ? CYC_START : CYC_DESEL;
      else if (active_q)
         kind = CYC_CONT;
      else
         kind = CYC_IDLE;

      if (!gw_n)
         wmask_raw = '1;
      else if (!bw_n)
         wmask_raw = ~lane_we_n;
      else
         wmask_raw = '0;

      step_go = (kind == CYC_CONT) && !adv_n && pstrb_n && cstrb_n;
      cnt_nx  = cnt_q + 2'(step_go);

      acc_addr = addr;
      wr_mask  = '0;
      rd_go    = 1'b0;
      case (kind)
         CYC_START: begin
            acc_addr = addr;
            // the processor strobe always reads; write inputs ignored
            wr_mask  = p_eff ? '0 : wmask_raw;
            rd_go    = p_eff ? 1'b1 : (wmask_raw == '0);
         end
         CYC_CONT: begin
            acc_addr = {base_q[ADDR_W-1 -: GRP_W],
                        burst_ofs(base_q[1:0], cnt_nx, burst_ilv)};
            wr_mask  = wmask_raw;
            rd_go    = (wmask_raw == '0);
         end
         default: begin
            acc_addr = addr;
         end
      endcase
      if (rst) begin
         wr_mask = '0;
         rd_go   = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         base_q   <= '0;
         cnt_q    <= '0;
      end else begin
         case (kind)
            CYC_START: begin
               active_q <= 1'b1;
               base_q   <= addr;
               cnt_q    <= '0;
            end
            CYC_DESEL: active_q <= 1'b0;
            CYC_CONT:  cnt_q    <= cnt_nx;
            default:   ;
         endcase
      end
   end

   // R1: a qualified processor strobe never produces a write
   p_pstrb_reads_r1: assert property (@(posedge clk) disable iff (rst)
      (!pstrb_n && !ce_main_n && ce_hi && !ce_lo_n) |-> (wr_mask == '0 && rd_go));

   // R5: advance held high keeps the burst position
   p_suspend_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (active_q && pstrb_n && cstrb_n && adv_n) |=> (cnt_q == $past(cnt_q)));

   // R5: advance low with both strobes high steps once
   p_advance_steps_r5: assert property (@(posedge clk) disable iff (rst)
      (active_q && pstrb_n && cstrb_n && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       acc_addr,
   input  logic [LANES-1:0]        wr_mask,
   input  logic                    rd_go,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rd_word
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [ADDR_W-1:0] rd_addr_q;

   always_ff @(posedge clk) begin
      if (rst)
         rd_addr_q <= '0;
      else if (rd_go)
         rd_addr_q <= acc_addr;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_mask[g])
            bank[acc_addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rd_word[g*LANE_W +: LANE_W] = bank[rd_addr_q];
   end

endmodule

// File: rtl/bsram_out.sv
module bsram_out #(
   parameter int DATA_W  = 32,
   parameter int LANES   = 4,
   parameter bit FLOW_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_go,
   input  logic [LANES-1:0]  wr_mask,
   input  logic [DATA_W-1:0] rd_word,
   input  logic              pipe_en,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   logic              rd_v1_q, rd_v2_q, wr_seen_q;
   logic [DATA_W-1:0] dout_q;
   logic [DATA_W-1:0] sel_data;
   logic              sel_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_v1_q   <= 1'b0;
         rd_v2_q   <= 1'b0;
         wr_seen_q <= 1'b0;
         dout_q    <= '0;
      end else begin
         rd_v1_q   <= rd_go;
         rd_v2_q   <= rd_v1_q;
         wr_seen_q <= |wr_mask;
         dout_q    <= rd_word;
      end
   end

   if (FLOW_OK) begin : g_both
      assign sel_data  = pipe_en ? dout_q  : rd_word;
      assign sel_valid = pipe_en ? rd_v2_q : rd_v1_q;
   end else begin : g_pipe_only
      logic unused_sel;
      assign unused_sel = pipe_en;
      assign sel_data   = dout_q;
      assign sel_valid  = rd_v2_q;
   end

   assign dout_en = sel_valid && !oe_n && !wr_seen_q;
   assign dout    = dout_en ? sel_data : '0;

   // R10: output enable inactive means an undriven bus
   p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
      oe_n |-> !dout_en);

   // R10: a byte write sampled on the last edge blocks the drive
   p_write_hiz_r10: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && (wr_mask != '0)) |-> !dout_en);

endmodule

// File: rtl/bsram_core.sv
module bsram_core #(
   parameter int ADDR_W  = 8,
   parameter int LANES   = 4,
   parameter int LANE_W  = 8,
   parameter bit FLOW_OK = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ce_main_n,
   input  logic                    ce_hi,
   input  logic                    ce_lo_n,
   input  logic                    pstrb_n,
   input  logic                    cstrb_n,
   input  logic                    adv_n,
   input  logic                    gw_n,
   input  logic                    bw_n,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic                    oe_n,
   input  logic                    burst_ilv,
   input  logic                    pipe_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("bsram_core: ADDR_W must lie in 2..12");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("bsram_core: LANES and LANE_W must be positive");
   end

   logic [ADDR_W-1:0] acc_addr;
   logic [LANES-1:0]  wr_mask;
   logic              rd_go;
   logic [DATA_W-1:0] rd_word;

   bsram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctl (
      .clk(clk), .rst(rst),
      .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
      .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
      .gw_n(gw_n), .bw_n(bw_n), .lane_we_n(lane_we_n),
      .addr(addr), .burst_ilv(burst_ilv),
      .acc_addr(acc_addr), .wr_mask(wr_mask), .rd_go(rd_go)
   );

   bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
      .clk(clk), .rst(rst),
      .acc_addr(acc_addr), .wr_mask(wr_mask), .rd_go(rd_go),
      .wdata(din), .rd_word(rd_word)
   );

   bsram_out #(.DATA_W(DATA_W), .LANES(LANES), .FLOW_OK(FLOW_OK)) i_out (
      .clk(clk), .rst(rst),
      .rd_go(rd_go), .wr_mask(wr_mask), .rd_word(rd_word),
      .pipe_en(pipe_en), .oe_n(oe_n),
      .dout(dout), .dout_en(dout_en)
   );

   // R12: the edge after reset leaves the bus undriven
   p_reset_quiet_r12: assert property (@(posedge clk)
      $past(rst) |-> !dout_en);

endmodule

// File: tb/test_bsram_core.sv
module test_bsram_core;
   logic        clk = 1'b0;
   logic        rst;
   logic        ce_main_n, ce_hi, ce_lo_n;
   logic        pstrb_n, cstrb_n, adv_n, gw_n, bw_n;
   logic [3:0]  lane_we_n;
   logic        oe_n, burst_ilv, pipe_en;
   logic [7:0]  addr;
   logic [31:0] din;
   logic [31:0] dout;
   logic        dout_en;

   int checks = 0;
   int fails  = 0;
   logic [31:0] model [256];

   always #5 clk = ~clk;

   bsram_core i_bsram_core (
      .clk(clk), .rst(rst),
      .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
      .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
      .gw_n(gw_n), .bw_n(bw_n), .lane_we_n(lane_we_n),
      .oe_n(oe_n), .burst_ilv(burst_ilv), .pipe_en(pipe_en),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   task automatic idle_in;
      ce_main_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
      pstrb_n = 1'b1; cstrb_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bw_n = 1'b1; lane_we_n = 4'hF;
   endtask

   task automatic chk(input string req, input logic en_e,
                      input logic [31:0] d_e, input bit use_d);
      checks++;
      if (dout_en !== en_e || (use_d && dout !== d_e)) begin
         fails++;
         $display("FAIL %s: dout_en=%0b dout=%h, expected dout_en=%0b dout=%h",
                  req, dout_en, dout, en_e, d_e);
      end
   endtask

   task automatic deselect;
      idle_in;
      cstrb_n = 1'b0; ce_hi = 1'b0;
      tick;
      idle_in;
      tick;
   endtask

   task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
      idle_in;
      cstrb_n = 1'b0; addr = a; gw_n = 1'b0; din = d;
      tick;
      idle_in;
      model[a] = d;
   endtask

   task automatic wr_bytes(input logic [7:0] a, input logic [31:0] d,
                           input logic [3:0] lanes_n);
      idle_in;
      cstrb_n = 1'b0; addr = a; bw_n = 1'b0; lane_we_n = lanes_n; din = d;
      tick;
      idle_in;
      for (int i = 0; i < 4; i++)
         if (!lanes_n[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
   endtask

   // flow-through single read, checked after the start edge
   task automatic rd_flow(input string req, input logic [7:0] a);
      deselect;
      pipe_en = 1'b0;
      pstrb_n = 1'b0; addr = a;
      tick;
      chk(req, 1'b1, model[a], 1'b1);
      idle_in;
   endtask

   task automatic rd_burst(input string req, input logic [7:0] a,
                           input logic ilv, input logic pipe);
      logic [7:0] ex [4];
      for (int k = 0; k < 4; k++)
         ex[k] = {a[7:2], ilv ? (a[1:0] ^ 2'(k)) : (a[1:0] + 2'(k))};
      deselect;
      burst_ilv = ilv; pipe_en = pipe;
      pstrb_n = 1'b0; addr = a;
      tick;
      if (pipe) chk({req, " R9 pipe first beat not yet"}, 1'b0, 32'h0, 1'b0);
      else      chk(req, 1'b1, model[ex[0]], 1'b1);
      pstrb_n = 1'b1; adv_n = 1'b0;
      for (int k = 1; k < 4; k++) begin
         tick;
         chk(req, 1'b1, pipe ? model[ex[k-1]] : model[ex[k]], 1'b1);
      end
      adv_n = 1'b1;
      tick;
      chk(req, 1'b1, model[ex[3]], 1'b1);
      idle_in;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      idle_in; oe_n = 1'b0; burst_ilv = 1'b0; pipe_en = 1'b0;
      addr = '0; din = '0;
      tick; tick;
      chk("R12 reset state", 1'b0, 32'h0, 1'b0);
      rst = 1'b0;
      tick;
      chk("R12 idle after reset", 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_global_write;
      wr_word(8'h10, 32'hA5A5_1234);
      wr_word(8'h40, 32'h4040_0000);
      wr_word(8'h41, 32'h4141_1111);
      wr_word(8'h30, 32'h3030_C0DE);
      rd_flow("R3 R8 controller-strobe global write", 8'h10);
      deselect;
      pipe_en = 1'b1;
      pstrb_n = 1'b0; addr = 8'h10;
      tick;
      chk("R9 pipelined: nothing after first edge", 1'b0, 32'h0, 1'b0);
      idle_in; adv_n = 1'b1;
      tick;
      chk("R9 pipelined: data after second edge", 1'b1, model[8'h10], 1'b1);
      idle_in;
   endtask

   task automatic t_burst_orders;
      logic [31:0] w [4];
      w[0] = 32'h2100_0001; w[1] = 32'h2200_0002;
      w[2] = 32'h2300_0003; w[3] = 32'h2000_0004;
      deselect;
      burst_ilv = 1'b0;
      cstrb_n = 1'b0; addr = 8'h21; gw_n = 1'b0; din = w[0];
      tick;
      cstrb_n = 1'b1; adv_n = 1'b0;
      for (int k = 1; k < 4; k++) begin
         din = w[k];
         tick;
      end
      idle_in;
      model[8'h21] = w[0]; model[8'h22] = w[1];
      model[8'h23] = w[2]; model[8'h20] = w[3];
      rd_burst("R6 interleaved pipelined", 8'h22, 1'b1, 1'b1);
      rd_burst("R7 linear flow-through", 8'h23, 1'b0, 1'b0);
      rd_burst("R6 interleaved flow-through", 8'h21, 1'b1, 1'b0);
      rd_burst("R7 linear pipelined", 8'h22, 1'b0, 1'b1);
   endtask

   task automatic t_byte_write;
      wr_bytes(8'h50, 32'h1111_1111, 4'h0);
      wr_bytes(8'h50, 32'hAABB_CCDD, 4'b1010);
      rd_flow("R8 lanes 0 and 2 written", 8'h50);
      deselect;
      cstrb_n = 1'b0; addr = 8'h50; bw_n = 1'b0; lane_we_n = 4'hF;
      din = 32'hDEAD_BEEF;
      tick;
      chk("R8 no lane strobe is a read", 1'b1, model[8'h50], 1'b1);
      idle_in;
      deselect;
      cstrb_n = 1'b0; addr = 8'h50; bw_n = 1'b1; lane_we_n = 4'h0;
      din = 32'hDEAD_BEEF;
      tick;
      chk("R8 byte-write enable high is a read", 1'b1, model[8'h50], 1'b1);
      idle_in;
   endtask

   task automatic t_pstrb_read_only;
      deselect;
      pipe_en = 1'b0; burst_ilv = 1'b0;
      pstrb_n = 1'b0; cstrb_n = 1'b0; addr = 8'h30;
      gw_n = 1'b0; bw_n = 1'b0; lane_we_n = 4'h0; adv_n = 1'b0;
      din = 32'hBAD0_BAD0;
      tick;
      chk("R1 R4 processor strobe reads offset 0, no write", 1'b1, model[8'h30], 1'b1);
      idle_in;
      rd_flow("R1 word unchanged after processor-strobe edge", 8'h30);
   endtask

   task automatic t_suspend_block;
      deselect;
      pipe_en = 1'b0; burst_ilv = 1'b0;
      pstrb_n = 1'b0; addr = 8'h40;
      tick;
      chk("R5 burst start", 1'b1, model[8'h40], 1'b1);
      idle_in;
      tick;
      chk("R5 advance high holds word", 1'b1, model[8'h40], 1'b1);
      adv_n = 1'b0;
      tick;
      chk("R5 advance low steps", 1'b1, model[8'h41], 1'b1);
      ce_main_n = 1'b1; pstrb_n = 1'b0; adv_n = 1'b0; addr = 8'h10;
      tick;
      chk("R2 blocked processor strobe, no step", 1'b1, model[8'h41], 1'b1);
      idle_in;
      ce_main_n = 1'b1; cstrb_n = 1'b0; addr = 8'h10;
      tick;
      chk("R2 controller strobe with master off deselects", 1'b0, 32'h0, 1'b0);
      idle_in;
      tick;
      chk("R11 burst ended after deselect", 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_oe_and_write;
      deselect;
      pipe_en = 1'b0; oe_n = 1'b1;
      pstrb_n = 1'b0; addr = 8'h40;
      tick;
      chk("R10 oe high keeps bus off", 1'b0, 32'h0, 1'b0);
      oe_n = 1'b0;
      #1;
      chk("R10 oe low drives without clock", 1'b1, model[8'h40], 1'b1);
      idle_in;
      bw_n = 1'b0; lane_we_n = 4'b1110; din = 32'h0000_00EE;
      tick;
      model[8'h40][7:0] = 8'hEE;
      chk("R10 byte write forces bus off", 1'b0, 32'h0, 1'b0);
      idle_in;
      tick;
      chk("R8 R10 continued read shows written lane", 1'b1, model[8'h40], 1'b1);
   endtask

   task automatic t_deselect_pipe;
      deselect;
      pipe_en = 1'b1;
      pstrb_n = 1'b0; addr = 8'h21;
      tick;
      idle_in;
      cstrb_n = 1'b0; ce_hi = 1'b0;
      tick;
      chk("R11 read before deselect still driven", 1'b1, model[8'h21], 1'b1);
      idle_in;
      tick;
      chk("R11 bus off one cycle later", 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_reset_mid;
      deselect;
      pipe_en = 1'b1;
      pstrb_n = 1'b0; addr = 8'h22;
      tick;
      idle_in;
      rst = 1'b1;
      tick;
      chk("R12 reset clears output stages", 1'b0, 32'h0, 1'b0);
      rst = 1'b0;
      tick; tick;
      chk("R12 burst state cleared", 1'b0, 32'h0, 1'b0);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      t_reset;
      t_global_write;
      t_burst_orders;
      t_byte_write;
      t_pstrb_read_only;
      t_suspend_block;
      t_oe_and_write;
      t_deselect_pipe;
      t_reset_mid;
      summary;
   end

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary;
   end

endmodule